// File: doc/BRIEF.md
# Link Symbol Scrambler/Descrambler

This block whitens the byte stream of a serial link with a pseudo-random keystream. It holds two identical byte-wide units. The transmit unit sits ahead of the line encoder and XORs data characters with the keystream. Idle fill, which is sent as data byte 0x00, is whitened the same way. The receive unit sits after the line decoder and applies the same keystream again, which recovers the original bytes. Each unit takes a byte, a control/data flag, a valid strobe and a scramble-disable input. Each gives back the processed byte and the flag one clock later.

The keystream comes from a 16-bit Galois shift register with polynomial x^16+x^5+x^4+x^3+1 and seed 0xFFFF. Both ends bring their generators back to the seed on the same comma character, so the two ends stay in step without any other coordination. The disable input lets test and debug link states send bytes in the clear. The generator keeps running while disable is high, so whitening resumes in step when disable drops.

Top module: `link_scrambler_pair`

## Requirements
- R1: After reset both units drive valid 0, byte 0 and flag 0, and their generators hold the seed 0xFFFF.
- R2: Each unit has a latency of exactly one clock: out_valid equals in_valid of the previous cycle, and the flag is passed through with the byte.
- R3: For a valid data byte (flag 0, disable 0), output = input XOR key. Key bit i (i = 0 first, LSB first) is bit 15 of the generator state after i steps. One step shifts the state left by one and, when the old bit 15 was 1, XORs the mask 0x0039. The state then advances 8 steps.
- R4: Idle fill, sent as data byte 0x00, is whitened: its output equals the key byte.
- R5: A valid control character (flag 1) is output unchanged with the flag still set.
- R6: A comma control character (0xBC, flag 1) sets the generator back to 0xFFFF, so the next data byte uses the seed key.
- R7: A skip control character (0x1C, flag 1) leaves the generator state unchanged.
- R8: Any other control character advances the generator 8 steps, just as a data byte does.
- R9: When disable is 1, data bytes are output unchanged, but the generator still advances 8 steps.
- R10: While valid is 0, the generator and the held output byte do not change, and out_valid is 0 on the next cycle.
- R11: The receive unit undoes the transmit unit: a byte stream looped from transmit into receive, with the disable inputs matched, comes out equal to the original stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both units |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_byte_i | input | 8 | Character to be whitened |
| tx_ctl_i | input | 1 | 1 = control character, 0 = data |
| tx_valid_i | input | 1 | Transmit character strobe |
| tx_bypass_i | input | 1 | Disable whitening on transmit |
| tx_byte_o | output | 8 | Whitened character |
| tx_ctl_o | output | 1 | Flag passed through |
| tx_valid_o | output | 1 | Transmit output strobe |
| rx_byte_i | input | 8 | Decoded character from the line |
| rx_ctl_i | input | 1 | 1 = control character, 0 = data |
| rx_valid_i | input | 1 | Receive character strobe |
| rx_bypass_i | input | 1 | Disable de-whitening on receive |
| rx_byte_o | output | 8 | Recovered character |
| rx_ctl_o | output | 1 | Flag passed through |
| rx_valid_o | output | 1 | Receive output strobe |

## Verification
A directed run of 0x00 fill bytes right after reset exposes the keystream directly, so a wrong tap mask or a wrong bit order shows up at once. Short directed sequences of comma, skip and other control characters, each followed by data, tell apart reseeding, holding and advancing the generator. A long constrained-random mix of data, control characters, valid gaps and disable toggles is then checked two ways. The transmit output is compared with a bench model of the generator, and the receive output, looped from transmit, is compared with the original bytes. The first comparison catches errors at one end only; the second catches a keystream mismatch between the two ends.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;

  localparam lfsr_t LFSR_SEED = 16'hFFFF;
  // x^16 + x^5 + x^4 + x^3 + 1 : low-order taps
  localparam lfsr_t LFSR_TAPS = 16'h0039;

  localparam logic [7:0] SYM_COMMA = 8'hBC;
  localparam logic [7:0] SYM_SKIP  = 8'h1C;

  // One Galois step: shift left, fold the dropped top bit back into the taps.
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[LFSR_W-2:0], 1'b0} ^ (s[LFSR_W-1] ? LFSR_TAPS : '0);
  endfunction
endpackage

// File: rtl/lsd_lfsr_gen.sv
module lsd_lfsr_gen
  import lsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              reseed_i,
  output lfsr_t             state_o,
  output logic [DATA_W-1:0] key_o
);
  localparam int STEPS = DATA_W;

  lfsr_t state_q;
  lfsr_t chain [STEPS+1];

  assign chain[0] = state_q;

  genvar gi;
  generate
    for (gi = 0; gi < STEPS; gi++) begin : g_step
      assign key_o[gi]    = chain[gi][LFSR_W-1];
      assign chain[gi+1]  = lfsr_step(chain[gi]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         state_q <= LFSR_SEED;
    else if (reseed_i)  state_q <= LFSR_SEED;
    else if (adv_i)     state_q <= chain[STEPS];
  end

  assign state_o = state_q;

  // R1: the state is never the all-zero lock-up value
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);  // R1
endmodule

// File: rtl/lsd_whiten_unit.sv
module lsd_whiten_unit
  import lsd_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] COMMA = SYM_COMMA,
  parameter logic [DATA_W-1:0] SKIP  = SYM_SKIP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              ctl_i,
  input  logic              valid_i,
  input  logic              bypass_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              ctl_o,
  output logic              valid_o
);
  // named events for the assertions
  logic ev_comma, ev_skip, ev_adv, ev_whiten;
  lfsr_t            gen_state;
  logic [DATA_W-1:0] key;

  assign ev_comma  = valid_i && ctl_i && (byte_i == COMMA);
  assign ev_skip   = valid_i && ctl_i && (byte_i == SKIP);
  assign ev_adv    = valid_i && !ev_comma && !ev_skip;
  assign ev_whiten = valid_i && !ctl_i && !bypass_i;

  lsd_lfsr_gen #(.DATA_W(DATA_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (ev_adv),
    .reseed_i (ev_comma),
    .state_o  (gen_state),
    .key_o    (key)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_o  <= '0;
      ctl_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ctl_o  <= ctl_i;
        byte_o <= ev_whiten ? (byte_i ^ key) : byte_i;
      end
    end
  end

  AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);  // R2
  AST_LAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);  // R10
  AST_CTL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ctl_i) |=> (ctl_o && byte_o == $past(byte_i)));  // R5
  AST_COMMA_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_comma |=> (gen_state == LFSR_SEED));  // R6
  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> $stable(gen_state));  // R7
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(gen_state) && $stable(byte_o)));  // R10
  AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !ctl_i && bypass_i) |=> (byte_o == $past(byte_i)));  // R9
  AST_BYPASS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !ctl_i && bypass_i) |=> (gen_state != $past(gen_state)));  // R9
endmodule

// File: rtl/link_scrambler_pair.sv
module link_scrambler_pair
  import lsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_ctl_i,
  input  logic              tx_valid_i,
  input  logic              tx_bypass_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_ctl_o,
  output logic              tx_valid_o,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_ctl_i,
  input  logic              rx_valid_i,
  input  logic              rx_bypass_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_ctl_o,
  output logic              rx_valid_o
);
  lsd_whiten_unit #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_i   (tx_byte_i),
    .ctl_i    (tx_ctl_i),
    .valid_i  (tx_valid_i),
    .bypass_i (tx_bypass_i),
    .byte_o   (tx_byte_o),
    .ctl_o    (tx_ctl_o),
    .valid_o  (tx_valid_o)
  );

  lsd_whiten_unit #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_i   (rx_byte_i),
    .ctl_i    (rx_ctl_i),
    .valid_i  (rx_valid_i),
    .bypass_i (rx_bypass_i),
    .byte_o   (rx_byte_o),
    .ctl_o    (rx_ctl_o),
    .valid_o  (rx_valid_o)
  );
endmodule

// File: tb/link_scrambler_pair_tb.sv
module link_scrambler_pair_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic       tx_ctl_i = 1'b0, tx_valid_i = 1'b0, tx_bypass_i = 1'b0;
  logic [7:0] tx_byte_o, rx_byte_o;
  logic       tx_ctl_o, tx_valid_o, rx_ctl_o, rx_valid_o;
  logic       rx_byp_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) rx_byp_d <= tx_bypass_i;

  link_scrambler_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_byte_i(tx_byte_i), .tx_ctl_i(tx_ctl_i), .tx_valid_i(tx_valid_i),
    .tx_bypass_i(tx_bypass_i),
    .tx_byte_o(tx_byte_o), .tx_ctl_o(tx_ctl_o), .tx_valid_o(tx_valid_o),
    .rx_byte_i(tx_byte_o), .rx_ctl_i(tx_ctl_o), .rx_valid_i(tx_valid_o),
    .rx_bypass_i(rx_byp_d),
    .rx_byte_o(rx_byte_o), .rx_ctl_o(rx_ctl_o), .rx_valid_o(rx_valid_o)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the generator
  logic [15:0] m_lfsr = 16'hFFFF;
  logic        p_v = 0, p_c = 0;
  logic [7:0]  p_b = 0;

  function automatic logic [15:0] m_tick(input logic [15:0] s);
    logic top = s[15];
    s = s << 1;
    if (top) s = s ^ 16'b0000_0000_0011_1001;
    return s;
  endfunction

  function automatic logic [7:0] m_key(input logic [15:0] s);
    logic [7:0] k;
    for (int i = 0; i < 8; i++) begin
      k[i] = s[15];
      s = m_tick(s);
    end
    return k;
  endfunction

  function automatic logic [15:0] m_adv8(input logic [15:0] s);
    for (int i = 0; i < 8; i++) s = m_tick(s);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at a negedge, check both ends at the following negedge
  task automatic step(input bit v, input bit c, input logic [7:0] b, input bit byp,
                      input string req);
    logic [7:0] exp_b;
    tx_valid_i = v; tx_ctl_i = c; tx_byte_i = b; tx_bypass_i = byp;
    exp_b = tx_byte_o;
    if (v) begin
      exp_b = (c || byp) ? b : (b ^ m_key(m_lfsr));
      if (c && b == 8'hBC)      m_lfsr = 16'hFFFF;
      else if (!(c && b == 8'h1C)) m_lfsr = m_adv8(m_lfsr);
    end
    @(negedge clk);
    check(tx_valid_o == v, {req, " R2 tx valid"}, 16'(tx_valid_o), 16'(v));
    check(tx_byte_o == exp_b, {req, " tx byte"}, 16'(tx_byte_o), 16'(exp_b));
    if (v) check(tx_ctl_o == c, {req, " R2 tx flag"}, 16'(tx_ctl_o), 16'(c));
    check(rx_valid_o == p_v, "R11 rx valid", 16'(rx_valid_o), 16'(p_v));
    if (p_v) begin
      check(rx_byte_o == p_b, "R11 rx byte", 16'(rx_byte_o), 16'(p_b));
      check(rx_ctl_o == p_c, "R11 rx flag", 16'(rx_ctl_o), 16'(p_c));
    end
    p_v = v;
    if (v) begin p_c = c; p_b = b; end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(tx_valid_o == 0 && rx_valid_o == 0, "R1 valid after reset",
          16'({tx_valid_o, rx_valid_o}), 16'h0);
    check(tx_byte_o == 0 && rx_byte_o == 0, "R1 byte after reset",
          {tx_byte_o, rx_byte_o}, 16'h0);
    rst_n = 1'b1;
    // R4 / R3: idle fill right after reset exposes the seed keystream
    step(1, 0, 8'h00, 0, "R4 idle seed");
    check(tx_byte_o == m_key(16'hFFFF), "R1 R3 first key from seed",
          16'(tx_byte_o), 16'(m_key(16'hFFFF)));
    step(1, 0, 8'h00, 0, "R4 idle");
    step(1, 0, 8'hA5, 0, "R3 data");
    // R6: comma reseeds
    step(1, 1, 8'hBC, 0, "R5 R6 comma");
    step(1, 0, 8'h00, 0, "R6 after comma");
    check(tx_byte_o == m_key(16'hFFFF), "R6 seed key after comma",
          16'(tx_byte_o), 16'(m_key(16'hFFFF)));
    // R7: skip holds, R8 other control advances
    step(1, 1, 8'h1C, 0, "R7 skip");
    step(1, 0, 8'h3C, 0, "R7 after skip");
    step(1, 1, 8'hF7, 0, "R8 other ctl");
    step(1, 0, 8'h00, 0, "R8 after ctl");
    // R9: bypass passes through and keeps generator moving
    step(1, 0, 8'h5A, 1, "R9 bypass");
    step(1, 0, 8'h00, 0, "R9 resume");
    // R10: valid gap
    step(0, 0, 8'hFF, 0, "R10 gap");
    step(0, 1, 8'hBC, 0, "R10 gap comma ignored");
    step(1, 0, 8'h00, 0, "R10 after gap");
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = $urandom_range(0, 99);
      logic [7:0] rb = 8'($urandom);
      if (r < 8)       step(0, 0, rb, 0, "R10 rnd gap");
      else if (r < 12) step(1, 1, 8'hBC, 0, "R6 rnd comma");
      else if (r < 16) step(1, 1, 8'h1C, 0, "R7 rnd skip");
      else if (r < 22) step(1, 1, rb, 0, "R8 rnd ctl");
      else if (r < 30) step(1, 0, rb, 1, "R9 rnd bypass");
      else if (r < 40) step(1, 0, 8'h00, 0, "R4 rnd idle");
      else             step(1, 0, rb, 0, "R3 rnd data");
    end
    step(0, 0, 8'h00, 0, "R11 drain");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule